// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Buffer Controller

This block holds the outgoing data for one bulk IN endpoint of a full-speed USB device. It keeps two packet buffers that are used alternately. The CPU pushes bytes one at a time into the buffer currently being filled. That buffer is committed for sending when it reaches `PKT_BYTES` bytes, or earlier when software writes the short-packet trigger. The serial engine reads the oldest committed buffer. It reports back IN tokens, host acknowledgements, underruns, stall transmissions and CLEAR_FEATURE requests.

For each IN token the block presents a handshake choice: send data, refuse with NAK, or answer with STALL. It also presents the head packet's length and bytes, and the DATA0/DATA1 toggle. A 9-bit control/status register gathers the service level, the sticky events and the interrupt enable. Sticky events clear when software writes 1 to them. One interrupt line is driven from the packet-delivered event.

Top module: `bulk_in_ep`

## Requirements
- R1: Written bytes fill the buffers in alternating order. A buffer is committed as soon as its `PKT_BYTES`-th byte is written. Committed packets are presented oldest first on `tx_len` / `tx_data`. `tx_len` is 0 when nothing is committed. The first byte is presented after an IN token, and `tx_rd` advances to the next byte.
- R2: Writing 1 to register bit 6 (short trigger) commits the partly filled buffer with its current length, zero included, if a buffer is free. Bit 6 always reads 0.
- R3: Register bit 0 (service) reads 1 while at most one packet is committed, and 0 while two are committed.
- R4: `hs` is encoded 0 = DATA, 1 = NAK, 2 = STALL. It is NAK when no packet is committed, and DATA otherwise. A set delivered bit does not cause NAK.
- R5: `pkt_ack` with a committed packet releases the head packet and sets bit 1 (delivered). Writing 1 to bit 1 clears it, and a hardware set in the same cycle wins. An IN token rewinds the head packet to its first byte for a retry.
- R6: `irq` equals delivered AND bit 7 (interrupt enable). Bit 7 is read/write and resets to 0.
- R7: Writing 1 to bit 2 (flush), or a `cfg_evt` pulse, empties both buffers and resets the toggle to DATA0. Bit 2 always reads 0.
- R8: An `under` pulse sets bit 3 (underrun). Writing 1 to bit 3 clears it. While `under` is high, `hs` is NAK unless a stall is forced. Underrun never drives `irq`.
- R9: Writing 1 to bit 5 forces a stall, and `hs` is STALL while bit 5 is set. `stall_sent` clears bit 5. If bit 5 was set at that moment, bit 4 (stall sent, write 1 to clear) is set. A stall that hardware raised on its own leaves bit 4 unchanged. `clr_feat` clears bit 5.
- R10: A byte written while both buffers are committed is dropped, and bit 8 (overflow, write 1 to clear) is set.
- R11: `pid_odd` flips on each accepted `pkt_ack`. It returns to 0 on flush, on `cfg_evt` and on `clr_feat`.
- R12: After reset, both buffers are empty, every status bit is 0, and the register reads 0x001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU byte write strobe |
| wr_data | input | 8 | CPU byte |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 9 | Register write value |
| reg_rdata | output | 9 | Register read value |
| in_tok | input | 1 | IN token seen for this endpoint |
| under | input | 1 | Transmit underrun event |
| tx_rd | input | 1 | Advance to next packet byte |
| pkt_ack | input | 1 | Host acknowledged the packet |
| stall_sent | input | 1 | A STALL handshake went on the bus |
| clr_feat | input | 1 | Host CLEAR_FEATURE (halt) on endpoint |
| cfg_evt | input | 1 | SET_CONFIGURATION or SET_INTERFACE seen |
| hs | output | 2 | Handshake choice |
| tx_data | output | 8 | Current packet byte |
| tx_len | output | clog2(PKT_BYTES)+1 | Head packet length |
| pid_odd | output | 1 | Data toggle, 1 = DATA1 |
| irq | output | 1 | Endpoint interrupt source |

## Verification
The bench builds the block with `PKT_BYTES` = 8. With that value, the commit on a full buffer, the overflow with both buffers committed, and the ping-pong wraparound all occur within a few dozen writes. A long random phase can therefore cross every full/empty transition many times. A behavioural queue model predicts every output and register bit on every cycle. This also covers the same-cycle cases: commit together with acknowledge, flush together with writes, and forcing a stall in the cycle it is sent.

// File: rtl/bulk_in_ep.sv
module bulk_in_ep #(
  parameter int PKT_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  input  logic                          reg_we,
  input  logic [8:0]                    reg_wdata,
  output logic [8:0]                    reg_rdata,
  input  logic                          in_tok,
  input  logic                          under,
  input  logic                          tx_rd,
  input  logic                          pkt_ack,
  input  logic                          stall_sent,
  input  logic                          clr_feat,
  input  logic                          cfg_evt,
  output logic [1:0]                    hs,
  output logic [7:0]                    tx_data,
  output logic [$clog2(PKT_BYTES):0]    tx_len,
  output logic                          pid_odd,
  output logic                          irq
);
  localparam int AW = $clog2(PKT_BYTES);
  localparam int CW = AW + 1;

  logic [7:0]    mem [2*PKT_BYTES];
  logic          wsel, rsel;
  logic [CW-1:0] wcnt, rcnt, len0, len1;
  logic [1:0]    ccnt;
  logic          done, undr, ssent, fstall, ie, ovf;

  wire           flush  = cfg_evt | (reg_we & reg_wdata[2]);
  wire           full   = (ccnt == 2'd2);
  wire           wr_ok  = wr_en & ~full;
  wire [CW-1:0]  wnext  = wcnt + CW'(wr_ok);
  wire           fill_c = (wnext == CW'(PKT_BYTES));
  wire           trig_c = reg_we & reg_wdata[6] & ~full & ~fill_c;
  wire           commit = fill_c | trig_c;
  wire           ack_ok = pkt_ack & (ccnt != 2'd0);
  wire [CW-1:0]  hlen   = rsel ? len1 : len0;

  always_ff @(posedge clk)
    if (wr_ok && !flush) mem[{wsel, wcnt[AW-1:0]}] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wsel <= 1'b0; rsel <= 1'b0;
      wcnt <= '0;   rcnt <= '0;
      len0 <= '0;   len1 <= '0;
      ccnt <= 2'd0; pid_odd <= 1'b0;
    end else begin
      if (commit) begin
        if (wsel) len1 <= wnext; else len0 <= wnext;
        wsel <= ~wsel;
        wcnt <= '0;
      end else begin
        wcnt <= wnext;
      end
      if (ack_ok) begin
        rsel <= ~rsel;
        rcnt <= '0;
      end else if (in_tok) begin
        rcnt <= '0;
      end else if (tx_rd && ccnt != 2'd0 && rcnt < hlen) begin
        rcnt <= rcnt + 1'b1;
      end
      ccnt <= ccnt + {1'b0, commit} - {1'b0, ack_ok};
      if (clr_feat) pid_odd <= 1'b0;
      else if (ack_ok) pid_odd <= ~pid_odd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; undr <= 1'b0; ssent <= 1'b0;
      fstall <= 1'b0; ie <= 1'b0; ovf <= 1'b0;
    end else begin
      if (ack_ok && !flush) done <= 1'b1;
      else if (reg_we && reg_wdata[1]) done <= 1'b0;
      if (under) undr <= 1'b1;
      else if (reg_we && reg_wdata[3]) undr <= 1'b0;
      if (stall_sent && fstall) ssent <= 1'b1;
      else if (reg_we && reg_wdata[4]) ssent <= 1'b0;
      if (clr_feat || stall_sent) fstall <= 1'b0;
      else if (reg_we && reg_wdata[5]) fstall <= 1'b1;
      if (reg_we) ie <= reg_wdata[7];
      if (wr_en && full) ovf <= 1'b1;
      else if (reg_we && reg_wdata[8]) ovf <= 1'b0;
    end
  end

  assign reg_rdata = {ovf, ie, 1'b0, fstall, ssent, undr, 1'b0, done, ~full};
  assign hs        = fstall ? 2'd2 : ((ccnt == 2'd0 || under) ? 2'd1 : 2'd0);
  assign tx_data   = mem[{rsel, rcnt[AW-1:0]}];
  assign tx_len    = (ccnt != 2'd0) ? hlen : '0;
  assign irq       = done & ie;

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ccnt == 2'd0 && !pid_odd));
  // R9
  ssent_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssent) |-> ($past(fstall) && $past(stall_sent)));
  // R9
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> !fstall);
  // R5
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pkt_ack));
  // R10
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(wr_en) && $past(ccnt) == 2'd2));
  // R11
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pid_odd != $past(pid_odd)) |-> ($past(pkt_ack) || !pid_odd));
  // R4
  nak_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccnt == 2'd0 && !fstall) |-> hs == 2'd1);
endmodule

// File: tb/test_bulk_in_ep.sv
module test_bulk_in_ep;
  localparam int P  = 8;
  localparam int LW = $clog2(P) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en, reg_we, in_tok, under, tx_rd, pkt_ack, stall_sent, clr_feat, cfg_evt;
  logic [7:0] wr_data;
  logic [8:0] reg_wdata, reg_rdata;
  logic [1:0] hs;
  logic [7:0] tx_data;
  logic [LW-1:0] tx_len;
  logic pid_odd, irq;

  always #4 clk = ~clk;

  bulk_in_ep #(.PKT_BYTES(P)) i_bulk_in_ep (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_tok(in_tok), .under(under), .tx_rd(tx_rd), .pkt_ack(pkt_ack),
    .stall_sent(stall_sent), .clr_feat(clr_feat), .cfg_evt(cfg_evt),
    .hs(hs), .tx_data(tx_data), .tx_len(tx_len), .pid_odd(pid_odd), .irq(irq));

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [7:0] bq[$], fq[$];
  int lq[$];
  int ri;
  bit m_done, m_undr, m_ssent, m_fst, m_ie, m_ovf, m_tog;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic clear_in();
    wr_en = 0; wr_data = 0; reg_we = 0; reg_wdata = 0; in_tok = 0; under = 0;
    tx_rd = 0; pkt_ack = 0; stall_sent = 0; clr_feat = 0; cfg_evt = 0;
  endtask

  task automatic compare();
    int n = lq.size();
    chk("R3 service bit", reg_rdata[0], n <= 1);
    chk("R5 delivered bit", reg_rdata[1], m_done);
    chk("R7 flush bit reads 0", reg_rdata[2], 0);
    chk("R8 underrun bit", reg_rdata[3], m_undr);
    chk("R9 stall sent bit", reg_rdata[4], m_ssent);
    chk("R9 force stall bit", reg_rdata[5], m_fst);
    chk("R2 trigger bit reads 0", reg_rdata[6], 0);
    chk("R6 enable bit", reg_rdata[7], m_ie);
    chk("R10 overflow bit", reg_rdata[8], m_ovf);
    chk("R4 handshake", hs, m_fst ? 2 : ((n == 0 || under) ? 1 : 0));
    chk("R6 irq", irq, m_done && m_ie);
    chk("R11 toggle", pid_odd, m_tog);
    chk("R1 tx_len", tx_len, n > 0 ? lq[0] : 0);
    if (n > 0 && ri < lq[0]) chk("R1 tx_data", tx_data, bq[ri]);
  endtask

  task automatic commit_fill();
    foreach (fq[i]) bq.push_back(fq[i]);
    lq.push_back(fq.size());
    fq.delete();
  endtask

  task automatic model_step();
    int n0 = lq.size();
    bit fl = cfg_evt || (reg_we && reg_wdata[2]);
    bit ack = pkt_ack && n0 > 0;
    bit fc = 0;
    if (wr_en && n0 == 2) m_ovf = 1; else if (reg_we && reg_wdata[8]) m_ovf = 0;
    if (ack && !fl) m_done = 1; else if (reg_we && reg_wdata[1]) m_done = 0;
    if (under) m_undr = 1; else if (reg_we && reg_wdata[3]) m_undr = 0;
    if (stall_sent && m_fst) m_ssent = 1; else if (reg_we && reg_wdata[4]) m_ssent = 0;
    if (clr_feat || stall_sent) m_fst = 0; else if (reg_we && reg_wdata[5]) m_fst = 1;
    if (reg_we) m_ie = reg_wdata[7];
    if (fl) begin
      bq.delete(); fq.delete(); lq.delete(); ri = 0; m_tog = 0;
    end else begin
      if (clr_feat) m_tog = 0; else if (ack) m_tog = ~m_tog;
      if (ack) begin
        repeat (lq[0]) void'(bq.pop_front());
        void'(lq.pop_front());
        ri = 0;
      end else if (in_tok) ri = 0;
      else if (tx_rd && n0 > 0 && ri < lq[0]) ri++;
      if (wr_en && n0 < 2) begin
        fq.push_back(wr_data);
        if (fq.size() == P) begin fc = 1; commit_fill(); end
      end
      if (!fc && reg_we && reg_wdata[6] && n0 < 2) commit_fill();
    end
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic wbytes(int k, int base);
    for (int i = 0; i < k; i++) begin wr_en = 1; wr_data = 8'(base + i); cyc(); end
  endtask

  task automatic wreg(logic [8:0] v);
    reg_we = 1; reg_wdata = v; cyc();
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    if (!finished) $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_in();
    ri = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R12 reset register", reg_rdata, 9'h001);
    chk("R12 reset len", tx_len, 0);
    cyc();
    wbytes(P, 8'h10);
    chk("R1 one full buffer", tx_len, P);
    wbytes(3, 8'h40);
    wreg(9'h040);
    chk("R3 two committed", reg_rdata[0], 0);
    wbytes(1, 8'h99);
    chk("R10 overflow", reg_rdata[8], 1);
    in_tok = 1; cyc();
    for (int i = 0; i < P; i++) begin tx_rd = 1; cyc(); end
    pkt_ack = 1; cyc();
    chk("R5 delivered set", reg_rdata[1], 1);
    chk("R6 irq masked", irq, 0);
    chk("R2 short len", tx_len, 3);
    wreg(9'h080);
    chk("R6 irq enabled", irq, 1);
    wreg(9'h082);
    chk("R4 data while delivered clear", hs, 0);
    under = 1; cyc();
    wreg(9'h008);
    wreg(9'h020);
    chk("R9 stall forced", hs, 2);
    stall_sent = 1; cyc();
    chk("R9 sent once", reg_rdata[5:4], 2'b01);
    stall_sent = 1; cyc();
    wreg(9'h010);
    wreg(9'h020);
    clr_feat = 1; cyc();
    pkt_ack = 1; cyc();
    wreg(9'h040);
    wreg(9'h004);
    chk("R7 flushed", tx_len, 0);
    wbytes(P, 8'h70);
    cfg_evt = 1; cyc();
    for (int c = 0; c < 4000; c++) begin
      wr_en = 1'($urandom); wr_data = 8'($urandom);
      if ($urandom % 6 == 0) begin
        reg_we = 1; reg_wdata = 9'($urandom);
        if ($urandom % 8 != 0) reg_wdata[2] = 0;
      end
      in_tok = ($urandom % 10 == 0);
      tx_rd = !in_tok && 1'($urandom);
      pkt_ack = ($urandom % 12 == 0);
      under = ($urandom % 20 == 0);
      stall_sent = ($urandom % 20 == 0);
      clr_feat = ($urandom % 25 == 0);
      cfg_evt = ($urandom % 80 == 0);
      cyc();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule